// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

The unit computes one integer quotient or remainder at a time. It serves twelve operation codes: signed and unsigned division on 64-bit operands or on their low 32-bit halves, extended division where the dividend is scaled up by the operand width before the divide, and signed and unsigned remainder. Both operands arrive on 64-bit inputs and the answer leaves as a 64-bit value that is ready to write back.

A one-cycle `start` pulse, taken while the unit is idle, captures the operation code and the operands. All codes share one radix-2 restoring datapath. Operands are reduced to magnitudes on entry, 64 shift-subtract steps follow, and signs are put back on the way out. `done` then pulses for one cycle with `result` valid. Every case with no defined answer gives zero: a zero divisor, a quotient that does not fit the destination width, and any unlisted code. The latency is the same for every code and every operand value.

Top module: `divmod_iter`

## Requirements
- R1: A `start` sampled high while idle is accepted. `done` is low on the following cycle and stays low until it rises exactly 65 clock edges after the accepting edge. It stays high for one cycle only.
- R2: A `start` that arrives while an operation is in flight is ignored. The running operation keeps its result and its timing, and no extra `done` follows.
- R3: The same operation issued again, including on the cycle `done` is high, gives the same result with the same single-cycle `done`.
- R4: Any divide or remainder whose divisor is zero returns 0. For word codes, a divisor is zero when its low 32 bits are zero.
- R5: Code 0, signed 64-bit divide, truncates toward zero. The most negative 64-bit value divided by -1 returns 0.
- R6: Code 1, unsigned 64-bit divide, returns the quotient. For example, 0x10000111 divided by 0x1111 gives 0x000000000000F001.
- R7: Code 2, signed word divide, uses only the low 32 bits of each operand and returns the quotient sign-extended to 64 bits. A quotient outside the 32-bit signed range returns 0, so 0xFFFFFFFF80000000 divided by -1 returns 0.
- R8: Code 3, unsigned word divide, uses only the low 32 bits and returns the quotient zero-extended.
- R9: Codes 4 and 5 (signed, unsigned) divide the dividend times 2^64 by the 64-bit divisor. Code 5 returns the quotient only when the divisor is greater than the dividend. Code 4 returns it only when it fits in 64 signed bits. Otherwise both return 0.
- R10: Codes 6 and 7 (signed, unsigned) divide the low 32 dividend bits times 2^32 by the low 32 divisor bits. They return the quotient zero-extended from 32 bits when it fits 32 signed bits (code 6) or 32 unsigned bits (code 7), and 0 otherwise.
- R11: Code 8 returns the signed 64-bit remainder, which takes the dividend's sign. Code 10 returns the signed remainder of the low 32-bit halves, sign-extended to 64 bits.
- R12: Code 9 returns the unsigned 64-bit remainder. Code 11 returns the unsigned remainder of the low 32 bits of each operand, zero-extended, and the upper halves have no effect.
- R13: The 4-bit code is decoded by field. Bits 3:2 select the group: 00 divide, 01 extended divide, 10 remainder. Bit 1 selects word width, and bit 0 = 0 means signed. Codes 12 to 15 return 0.
- R14: During and after reset, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request strobe |
| op | input | 4 | Operation code (see R13) |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Write-back value, valid while `done` is high |

## Verification
Every result is due 65 edges after the edge that accepts `start`, whatever the code or operands. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the acceptance and checks that `done` is low on the first sample and first goes high on sample 65, where `result` is compared. For the ignored-start case the bench pulses `start` partway through a run, checks that the first answer still lands on sample 65, and then watches a further window longer than one full latency for any stray `done`. Back-to-back requests are issued on the very sample where `done` is seen, so the next acceptance falls on the first edge the unit is idle again.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    localparam int XLEN    = 64;
    localparam int HLEN    = XLEN / 2;
    localparam int ITERS   = XLEN;
    localparam int LATENCY = ITERS + 1;
    localparam int CNT_W   = $clog2(ITERS);

    typedef enum logic [1:0] {
        GRP_DIV  = 2'b00,
        GRP_DIVX = 2'b01,
        GRP_MOD  = 2'b10,
        GRP_RSVD = 2'b11
    } op_grp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } core_state_e;

    typedef struct packed {
        op_grp_e grp;
        logic    word;
        logic    sgn;
    } op_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] dvs;
    } core_load_t;

    typedef struct packed {
        op_dec_t dec;
        logic    q_neg;
        logic    r_neg;
        logic    kill;
    } ctx_t;

    function automatic op_dec_t decode_op(input logic [3:0] code);
        op_dec_t d;
        d.grp  = op_grp_e'(code[3:2]);
        d.word = code[1];
        d.sgn  = ~code[0];
        return d;
    endfunction

    function automatic logic [XLEN-1:0] sext_half(input logic [HLEN-1:0] x);
        return {{HLEN{x[HLEN-1]}}, x};
    endfunction

    function automatic logic [XLEN-1:0] zext_half(input logic [HLEN-1:0] x);
        return {{HLEN{1'b0}}, x};
    endfunction

endpackage

// File: rtl/divmod_prep.sv
module divmod_prep
    import divmod_pkg::*;
(
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output core_load_t      ld,
    output ctx_t            ctx
);

    op_dec_t         dec;
    logic [XLEN-1:0] a_x;
    logic [XLEN-1:0] b_x;
    logic [XLEN-1:0] a_mag;
    logic [XLEN-1:0] b_mag;
    logic            a_neg;
    logic            b_neg;

    always_comb begin
        dec = decode_op(op);

        // Narrow word operands to their low half, extended per signedness.
        if (dec.word) begin
            a_x = dec.sgn ? sext_half(dividend[HLEN-1:0]) : zext_half(dividend[HLEN-1:0]);
            b_x = dec.sgn ? sext_half(divisor[HLEN-1:0])  : zext_half(divisor[HLEN-1:0]);
        end else begin
            a_x = dividend;
            b_x = divisor;
        end

        a_neg = dec.sgn & a_x[XLEN-1];
        b_neg = dec.sgn & b_x[XLEN-1];
        a_mag = a_neg ? -a_x : a_x;
        b_mag = b_neg ? -b_x : b_x;

        // Two-word dividend {hi, lo}; hi must stay below the divisor.
        ld.dvs = b_mag;
        if (dec.grp == GRP_DIVX && !dec.word) begin
            ld.hi = a_mag;
            ld.lo = '0;
        end else if (dec.grp == GRP_DIVX) begin
            ld.hi = '0;
            ld.lo = {a_mag[HLEN-1:0], {HLEN{1'b0}}};
        end else begin
            ld.hi = '0;
            ld.lo = a_mag;
        end

        ctx.dec   = dec;
        ctx.q_neg = a_neg ^ b_neg;
        ctx.r_neg = a_neg;
        // hi >= divisor covers both a zero divisor and extended overflow.
        ctx.kill  = (ld.hi >= ld.dvs) | (dec.grp == GRP_RSVD);
    end

endmodule

// File: rtl/divmod_core.sv
module divmod_core
    import divmod_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  core_load_t      ld,
    output logic            busy,
    output logic            fin,
    output logic [XLEN-1:0] q_mag,
    output logic [XLEN-1:0] r_mag
);

    core_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN-1:0]  rem_q;
    logic [XLEN-1:0]  quo_q;
    logic [XLEN-1:0]  dvs_q;

    logic [XLEN:0]    shifted;
    logic [XLEN+1:0]  trial;
    logic             take;
    logic [XLEN-1:0]  rem_nx;
    logic [XLEN-1:0]  quo_nx;

    // One restoring step: shift in the next dividend bit, try a subtract.
    always_comb begin
        shifted = {rem_q, quo_q[XLEN-1]};
        trial   = {1'b0, shifted} - {2'b00, dvs_q};
        take    = ~trial[XLEN+1];
        rem_nx  = take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        quo_nx  = {quo_q[XLEN-2:0], take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        rem_q   <= ld.hi;
                        quo_q   <= ld.lo;
                        dvs_q   <= ld.dvs;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(ITERS - 1)) begin
                        state_q <= ST_FIN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign fin   = (state_q == ST_FIN);
    assign q_mag = quo_q;
    assign r_mag = rem_q;

endmodule

// File: rtl/divmod_post.sv
module divmod_post
    import divmod_pkg::*;
(
    input  ctx_t            ctx,
    input  logic [XLEN-1:0] q_mag,
    input  logic [XLEN-1:0] r_mag,
    output logic [XLEN-1:0] res
);

    localparam logic [XLEN-1:0] WORD_LIM = XLEN'(1) << (HLEN - 1);
    localparam logic [XLEN-1:0] FULL_LIM = XLEN'(1) << (XLEN - 1);

    logic [XLEN-1:0] lim;
    logic [XLEN-1:0] q_val;
    logic [XLEN-1:0] r_val;
    logic            s_fit;
    logic            u_fit;
    logic            fit;

    always_comb begin
        lim   = ctx.dec.word ? WORD_LIM : FULL_LIM;
        q_val = ctx.q_neg ? -q_mag : q_mag;
        r_val = ctx.r_neg ? -r_mag : r_mag;

        // A negative quotient may reach the limit, a positive one may not.
        s_fit = ctx.q_neg ? (q_mag <= lim) : (q_mag < lim);
        u_fit = !ctx.dec.word || (q_mag[XLEN-1:HLEN] == '0);
        fit   = ctx.dec.sgn ? s_fit : u_fit;

        res = '0;
        case (ctx.dec.grp)
            GRP_DIV: begin
                if (fit) begin
                    if (ctx.dec.word) begin
                        res = ctx.dec.sgn ? sext_half(q_val[HLEN-1:0]) : zext_half(q_val[HLEN-1:0]);
                    end else begin
                        res = q_val;
                    end
                end
            end
            GRP_DIVX: begin
                if (fit) begin
                    res = ctx.dec.word ? zext_half(q_val[HLEN-1:0]) : q_val;
                end
            end
            GRP_MOD: begin
                if (ctx.dec.word) begin
                    res = ctx.dec.sgn ? sext_half(r_val[HLEN-1:0]) : zext_half(r_val[HLEN-1:0]);
                end else begin
                    res = r_val;
                end
            end
            default: res = '0;
        endcase

        if (ctx.kill) begin
            res = '0;
        end
    end

endmodule

// File: rtl/divmod_iter.sv
module divmod_iter
    import divmod_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            done,
    output logic [XLEN-1:0] result
);

    core_load_t      ld;
    ctx_t            ctx_in;
    ctx_t            ctx_q;
    logic            core_busy;
    logic            core_fin;
    logic            accept;
    logic [XLEN-1:0] q_mag;
    logic [XLEN-1:0] r_mag;
    logic [XLEN-1:0] post_res;

    divmod_prep u_prep (
        .op       (op),
        .dividend (dividend),
        .divisor  (divisor),
        .ld       (ld),
        .ctx      (ctx_in)
    );

    assign accept = start & ~core_busy;

    divmod_core u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .ld    (ld),
        .busy  (core_busy),
        .fin   (core_fin),
        .q_mag (q_mag),
        .r_mag (r_mag)
    );

    divmod_post u_post (
        .ctx   (ctx_q),
        .q_mag (q_mag),
        .r_mag (r_mag),
        .res   (post_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            if (accept) begin
                ctx_q <= ctx_in;
            end
            done <= core_fin;
            if (core_fin) begin
                result <= post_res;
            end
        end
    end

endmodule

// File: rtl/divmod_iter_chk.sv
module divmod_iter_chk
    import divmod_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [2:0]      op_hi,
    input logic [XLEN-1:0] divisor,
    input logic            done,
    input logic [XLEN-1:0] result
);

    logic       bsy;
    logic [7:0] cnt;
    logic       zero_q;
    logic       rsvd_q;
    logic       take;
    logic       zero_now;

    assign take     = start && (!bsy || done);
    assign zero_now = op_hi[0] ? (divisor[HLEN-1:0] == '0) : (divisor == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bsy    <= 1'b0;
            cnt    <= '0;
            zero_q <= 1'b0;
            rsvd_q <= 1'b0;
        end else if (take) begin
            bsy    <= 1'b1;
            cnt    <= '0;
            zero_q <= zero_now;
            rsvd_q <= (op_hi[2:1] == 2'b11);
        end else if (done) begin
            bsy <= 1'b0;
        end else if (bsy) begin
            cnt <= cnt + 8'd1;
        end
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_due_cycle: assert property (@(posedge clk) disable iff (rst)
        done |-> (bsy && cnt == 8'(LATENCY)));

    a_r2_no_early_done: assert property (@(posedge clk) disable iff (rst)
        (bsy && cnt < 8'(LATENCY)) |-> !done);

    a_r4_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (done && zero_q) |-> (result == '0));

    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (done && rsvd_q) |-> (result == '0));

    a_r14_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && result == '0));

endmodule

bind divmod_iter divmod_iter_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_hi   (op[3:1]),
    .divisor (divisor),
    .done    (done),
    .result  (result)
);

// File: tb/divmod_iter_bench.sv
`timescale 1ns/1ps
module divmod_iter_bench;

    localparam int LAT = 65;
    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] NEG1  = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        done_o;
    logic [63:0] res_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    divmod_iter u_divmod_iter (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .op       (op_i),
        .dividend (a_i),
        .divisor  (b_i),
        .done     (done_o),
        .result   (res_o)
    );

    function automatic logic [63:0] next_rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic bit fits_s(input logic signed [127:0] q, input int w);
        logic signed [127:0] hi_lim;
        logic signed [127:0] lo_lim;
        hi_lim = (128'sd1 <<< (w - 1)) - 128'sd1;
        lo_lim = -(128'sd1 <<< (w - 1));
        return (q <= hi_lim) && (q >= lo_lim);
    endfunction

    // Behavioural model written from the requirements.
    function automatic logic [63:0] ref_result(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
        logic signed [127:0] na, nb, q, r;
        logic [127:0] uq;
        logic [63:0]  t;
        logic [31:0]  a32, b32;
        logic [63:0]  res;
        a32 = a[31:0];
        b32 = b[31:0];
        res = '0;
        na = '0; nb = '0; q = '0; r = '0; uq = '0; t = '0;
        case (o)
            4'd0: if (b != 0) begin
                na = $signed({{64{a[63]}}, a}); nb = $signed({{64{b[63]}}, b});
                q = na / nb;
                if (fits_s(q, 64)) res = q[63:0];
            end
            4'd1: if (b != 0) res = a / b;
            4'd2: if (b32 != 0) begin
                na = $signed({{96{a32[31]}}, a32}); nb = $signed({{96{b32[31]}}, b32});
                q = na / nb;
                if (fits_s(q, 32)) res = {{32{q[31]}}, q[31:0]};
            end
            4'd3: if (b32 != 0) res = {32'b0, a32 / b32};
            4'd4: if (b != 0) begin
                na = $signed({a, 64'b0}); nb = $signed({{64{b[63]}}, b});
                q = na / nb;
                if (fits_s(q, 64)) res = q[63:0];
            end
            4'd5: if (b != 0 && b > a) begin
                uq = {a, 64'b0} / {64'b0, b};
                res = uq[63:0];
            end
            4'd6: if (b32 != 0) begin
                na = $signed({{64{a32[31]}}, a32, 32'b0}); nb = $signed({{96{b32[31]}}, b32});
                q = na / nb;
                if (fits_s(q, 32)) res = {32'b0, q[31:0]};
            end
            4'd7: if (b32 != 0) begin
                t = {a32, 32'b0} / {32'b0, b32};
                if (t[63:32] == 0) res = {32'b0, t[31:0]};
            end
            4'd8: if (b != 0) begin
                na = $signed({{64{a[63]}}, a}); nb = $signed({{64{b[63]}}, b});
                r = na % nb;
                res = r[63:0];
            end
            4'd9: if (b != 0) res = a % b;
            4'd10: if (b32 != 0) begin
                na = $signed({{96{a32[31]}}, a32}); nb = $signed({{96{b32[31]}}, b32});
                r = na % nb;
                res = {{32{r[31]}}, r[31:0]};
            end
            4'd11: if (b32 != 0) res = {32'b0, a32 % b32};
            default: res = '0;
        endcase
        return res;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one operation at a falling edge; check timing (R1) and value.
    task automatic run_op(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] exp, input string req);
        int k;
        bit seen;
        op_i = o; a_i = a; b_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 done low after accept", {63'b0, done_o}, 64'd0);
        k = 0;
        seen = 0;
        while (!seen && k < 200) begin
            @(negedge clk);
            k++;
            if (done_o) seen = 1;
        end
        chk("R1 latency", 64'(k), 64'(LAT));
        chk(req, res_o, exp);
    endtask

    task automatic run_ref(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b, input string req);
        run_op(o, a, b, ref_result(o, a, b), req);
    endtask

    task automatic gen_pair(output logic [63:0] a, output logic [63:0] b);
        logic [63:0] r1, r2, s;
        r1 = next_rnd(); r2 = next_rnd(); s = next_rnd();
        a = r1 >> s[5:0];
        b = r2 >> s[11:6];
        if (s[12]) a = -a;
        if (s[13]) b = -b;
        if (s[14]) b = b & 64'h0000_0000_0000_FFFF;
    endtask

    task automatic t_reset();
        chk("R14 done after reset", {63'b0, done_o}, 64'd0);
        chk("R14 result after reset", res_o, 64'd0);
    endtask

    task automatic t_example_repeat();
        run_op(4'd1, 64'h10000111, 64'h1111, 64'h000000000000F001, "R6 example quotient");
        run_op(4'd1, 64'h10000111, 64'h1111, 64'h000000000000F001, "R3 repeat same result");
        chk("R3 done single cycle", {63'b0, done_o}, 64'd1);
        @(negedge clk);
        chk("R3 done dropped", {63'b0, done_o}, 64'd0);
    endtask

    task automatic t_busy_ignore();
        int k;
        bit seen;
        bit extra;
        op_i = 4'd1; a_i = 64'h10000111; b_i = 64'h1111; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        k = 0; seen = 0;
        while (!seen && k < 200) begin
            @(negedge clk);
            k++;
            if (k == 20) begin
                op_i = 4'd8; a_i = 64'd77; b_i = 64'd5; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) seen = 1;
        end
        chk("R2 latency kept", 64'(k), 64'(LAT));
        chk("R2 result kept", res_o, 64'h000000000000F001);
        extra = 0;
        for (int i = 0; i < LAT + 15; i++) begin
            @(negedge clk);
            if (done_o) extra = 1;
        end
        chk("R2 no extra done", {63'b0, extra}, 64'd0);
    endtask

    task automatic t_zero_div();
        for (int c = 0; c < 12; c++) begin
            run_op(4'(c), next_rnd(), 64'd0, 64'd0, "R4 zero divisor");
        end
        run_op(4'd2,  64'd1234, 64'hFFFF_0000_0000_0000, 64'd0, "R4 word zero low half");
        run_op(4'd11, 64'd1234, 64'h0000_0001_0000_0000, 64'd0, "R4 word remainder zero low half");
    endtask

    task automatic t_sdiv64();
        logic [63:0] a, b;
        run_op(4'd0, MIN64, NEG1, 64'd0, "R5 min by minus one");
        run_op(4'd0, -64'd7, 64'd2, -64'd3, "R5 negative truncation");
        run_op(4'd0, 64'd7, -64'd2, -64'd3, "R5 negative divisor");
        run_op(4'd0, -64'd8, -64'd2, 64'd4, "R5 both negative");
        run_op(4'd0, MIN64, 64'd1, MIN64, "R5 min by one");
        for (int i = 0; i < 12; i++) begin gen_pair(a, b); run_ref(4'd0, a, b, "R5 random"); end
    endtask

    task automatic t_udiv64();
        logic [63:0] a, b;
        run_op(4'd1, NEG1, 64'd1, NEG1, "R6 all ones by one");
        for (int i = 0; i < 12; i++) begin gen_pair(a, b); run_ref(4'd1, a, b, "R6 random"); end
    endtask

    task automatic t_word_div();
        logic [63:0] a, b;
        run_op(4'd2, 64'hFFFF_FFFF_8000_0000, NEG1, 64'd0, "R7 word min by minus one");
        run_op(4'd2, 64'h1234_5678_FFFF_FFF9, 64'h0000_0000_0000_0002, -64'd3, "R7 sign-extended quotient");
        run_op(4'd3, 64'hDEAD_0000_FFFF_FFFF, 64'h5555_0000_0000_0002, 64'h0000_0000_7FFF_FFFF, "R8 low halves only");
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd2, a, b, "R7 random"); end
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd3, a, b, "R8 random"); end
    endtask

    task automatic t_ext_dw();
        logic [63:0] a, b;
        run_op(4'd5, 64'd1, 64'd2, MIN64, "R9 unsigned extended half");
        run_op(4'd5, 64'd5, 64'd5, 64'd0, "R9 divisor equal dividend");
        run_op(4'd5, 64'd5, 64'd4, 64'd0, "R9 divisor below dividend");
        run_op(4'd4, 64'd1, 64'd4, 64'h4000_0000_0000_0000, "R9 signed extended fits");
        run_op(4'd4, 64'd1, 64'd2, 64'd0, "R9 signed extended positive overflow");
        run_op(4'd4, NEG1, 64'd2, MIN64, "R9 signed extended negative limit");
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd4, a, b, "R9 random signed"); end
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd5, a, b, "R9 random unsigned"); end
    endtask

    task automatic t_ext_w();
        logic [63:0] a, b;
        run_op(4'd7, 64'd1, 64'd2, 64'h0000_0000_8000_0000, "R10 unsigned word extended");
        run_op(4'd7, 64'd2, 64'd2, 64'd0, "R10 unsigned word overflow");
        run_op(4'd6, 64'd1, 64'd2, 64'd0, "R10 signed word overflow");
        run_op(4'd6, NEG1, 64'd2, 64'h0000_0000_8000_0000, "R10 signed word negative limit");
        run_op(4'd6, 64'd1, 64'd4, 64'h0000_0000_4000_0000, "R10 signed word fits");
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd6, a, b, "R10 random signed"); end
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd7, a, b, "R10 random unsigned"); end
    endtask

    task automatic t_smod();
        logic [63:0] a, b;
        run_op(4'd8, -64'd7, 64'd2, NEG1, "R11 remainder takes dividend sign");
        run_op(4'd8, 64'd7, -64'd2, 64'd1, "R11 positive dividend");
        run_op(4'd8, MIN64, NEG1, 64'd0, "R11 min by minus one");
        run_op(4'd10, 64'h1234_5678_FFFF_FFF9, 64'd2, NEG1, "R11 word remainder sign-extended");
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd8, a, b, "R11 random"); end
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd10, a, b, "R11 random word"); end
    endtask

    task automatic t_umod();
        logic [63:0] a, b;
        run_op(4'd9, NEG1, 64'd10, 64'd5, "R12 unsigned remainder");
        run_op(4'd11, 64'hFFFF_FFFF_0000_0007, 64'hAAAA_0000_0000_0003, 64'd1, "R12 upper halves ignored");
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd9, a, b, "R12 random"); end
        for (int i = 0; i < 10; i++) begin gen_pair(a, b); run_ref(4'd11, a, b, "R12 random word"); end
    endtask

    task automatic t_reserved();
        for (int c = 12; c < 16; c++) begin
            run_op(4'(c), 64'd100, 64'd7, 64'd0, "R13 reserved code");
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example_repeat();
        t_busy_ignore();
        t_zero_div();
        t_sdiv64();
        t_udiv64();
        t_word_div();
        t_ext_dw();
        t_ext_w();
        t_smod();
        t_umod();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule